// File: doc/BRIEF.md
# Compare and Rollover General Timer

This block is a memory-mapped up-counting timer with one compare channel and a wrap indication. Software reaches it through a small word-addressed register port. The port selects one of six registers: control, prescaler, status, interrupt enable, compare value and counter. The counter advances on a tick made by dividing the input clock by a programmable ratio. When the count reaches the compare value, a match flag is set. When the count wraps from all ones back to zero, a wrap flag is set. A single level interrupt is raised while the timer is enabled and at least one flag that is also enabled is set.

Two counting styles exist. In free-run mode the counter passes through the compare value and keeps going. In restart mode the tick after a match reloads the counter to zero, so the timer produces periodic matches. An enable-mode bit decides whether turning the timer on also clears the count. A self-clearing software-reset bit returns most of the block to its idle state. Several control fields are kept only so that software can read them back; they have no effect on behaviour.

Top module: `gp_cmp_timer`

## Requirements
- R1: Registers by word index: 0 control, 1 prescaler, 2 status, 3 interrupt enable, 4 compare, 9 counter (read-only). Any other index reads as zero and ignores writes, and a write to index 9 is also ignored. After reset every register reads zero and the interrupt is low. The prescaler keeps only its low 12 bits, and the upper bits read as zero.
- R2: Writing control with bit 15 set does three things. It zeroes status, prescaler, interrupt enable, compare and counter. It stores the written control value with bits 0, 2, 3, 4 and 15 forced to zero. Bit 15 never reads back as 1. All other control bits are stored as written.
- R3: While control bit 0 (enable) is 1, the counter increases by one on every tick. While enable is 0, the counter holds its value.
- R4: A tick occurs once every (prescaler + 1) clock cycles while enabled. The divider restarts when the timer is disabled, so the first tick comes prescaler + 1 cycles after the enabling write.
- R5: A write that changes enable from 0 to 1 with control bit 1 (enable mode) also set clears the counter to zero in that cycle. With bit 1 clear, the counter keeps its previous value.
- R6: Status bit 0 is set in the cycle the counter takes on the compare value. With control bit 9 set (free-run), the counter keeps counting past the match.
- R7: Writing 1 to status bit 0 or bit 5 clears that flag. Writing 0 to a flag leaves it unchanged.
- R8: Interrupt-enable bit 0 enables the match flag and bit 5 enables the wrap flag. The interrupt output is 1 only when enable is 1 and some flag is set together with its enable bit.
- R9: With control bit 9 clear (restart), a tick that finds the counter equal to the compare value loads zero instead of incrementing.
- R10: Status bit 5 is set when an incrementing tick takes the counter from all ones to zero.
- R11: When a write-one-to-clear and a hardware set of the same flag fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register (combinational) |
| irq | output | 1 | Level interrupt |

## Verification
The bench targets the exact tick timing under a prescaler. It also covers the first tick after enabling, which exposes a divider that is not restarted on disable or that is off by one cycle. It times a status clear to land on the same edge as a compare match: a design that lets the clear win would lose the event. It checks the software reset's partial clearing of control, the difference between free-run and restart around the match, and a wrap from all ones. A design that confused these would leave the count running past the compare value, or would never raise the wrap flag. It also confirms that the interrupt drops when enable is cleared while a flag stays pending.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  // Register word indices
  localparam int unsigned IDX_CTRL = 0;
  localparam int unsigned IDX_PRE  = 1;
  localparam int unsigned IDX_STAT = 2;
  localparam int unsigned IDX_IEN  = 3;
  localparam int unsigned IDX_CMP  = 4;
  localparam int unsigned IDX_CNT  = 9;

  // Control bit positions
  localparam int unsigned CB_EN    = 0;
  localparam int unsigned CB_CLRON = 1;
  localparam int unsigned CB_FREE  = 9;
  localparam int unsigned CB_SRST  = 15;

  // Control bits dropped by a software reset
  localparam logic [31:0] SRST_DROP = 32'h0000_801D;

  // Flag positions on the bus
  localparam int unsigned FB_MATCH = 0;
  localparam int unsigned FB_WRAP  = 5;

  typedef struct packed {
    logic wrap;
    logic match;
  } flags_t;

  function automatic logic [31:0] flags_to_word(flags_t f);
    logic [31:0] w;
    w = '0;
    w[FB_MATCH] = f.match;
    w[FB_WRAP]  = f.wrap;
    return w;
  endfunction

  function automatic flags_t word_to_flags(logic [31:0] w);
    flags_t f;
    f.match = w[FB_MATCH];
    f.wrap  = w[FB_WRAP];
    return f;
  endfunction
endpackage

// File: rtl/gpt_prescaler.sv
module gpt_prescaler #(
  parameter int unsigned PRE_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [PRE_W-1:0] ratio_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] div_q, div_d;
  logic             at_end;

  assign at_end = (div_q >= ratio_i);

  always_comb begin
    div_d = div_q;
    if (!run_i) begin
      div_d = '0;
    end else if (at_end) begin
      div_d = '0;
    end else begin
      div_d = div_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else begin
      div_q <= div_d;
    end
  end

  assign tick_o = run_i & at_end;
endmodule

// File: rtl/gpt_counter.sv
module gpt_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             clear_i,
  input  logic             free_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             match_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] ALL_ONES = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             match_d, wrap_d;

  assign cnt_en = clear_i | tick_i;

  always_comb begin
    cnt_d   = cnt_q;
    match_d = 1'b0;
    wrap_d  = 1'b0;
    if (clear_i) begin
      cnt_d = '0;
    end else if (tick_i) begin
      if (!free_i && (cnt_q == cmp_i)) begin
        cnt_d = '0;
      end else begin
        cnt_d  = cnt_q + 1'b1;
        wrap_d = (cnt_q == ALL_ONES);
      end
      match_d = (cnt_d == cmp_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o   = cnt_q;
  assign match_o = match_d;
  assign wrap_o  = wrap_d;
endmodule

// File: rtl/gpt_status.sv
module gpt_status
  import gpt_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wipe_i,
  input  logic   ack_we_i,
  input  flags_t ack_i,
  input  flags_t set_i,
  input  flags_t ien_i,
  input  logic   run_i,
  output flags_t flags_o,
  output logic   irq_o
);
  flags_t flg_q, flg_d;
  flags_t ack_mask;

  always_comb begin
    ack_mask = ack_we_i ? ack_i : '0;
    if (wipe_i) begin
      flg_d = '0;
    end else begin
      flg_d = (flg_q & ~ack_mask) | set_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg_q <= '0;
    end else begin
      flg_q <= flg_d;
    end
  end

  assign flags_o = flg_q;
  assign irq_o   = run_i & (|(flg_q & ien_i));
endmodule

// File: rtl/gp_cmp_timer.sv
module gp_cmp_timer
  import gpt_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned PRE_W  = 12,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  localparam int unsigned SYNC_STAGES = 2;

  // Reset: asynchronous assertion, synchronous release
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[SYNC_STAGES-1];

  // Address decode
  logic wr_any, wr_ctrl, wr_pre, wr_stat, wr_ien, wr_cmp;
  assign wr_any  = bus_sel & bus_wr;
  assign wr_ctrl = wr_any & (bus_addr == ADDR_W'(IDX_CTRL));
  assign wr_pre  = wr_any & (bus_addr == ADDR_W'(IDX_PRE));
  assign wr_stat = wr_any & (bus_addr == ADDR_W'(IDX_STAT));
  assign wr_ien  = wr_any & (bus_addr == ADDR_W'(IDX_IEN));
  assign wr_cmp  = wr_any & (bus_addr == ADDR_W'(IDX_CMP));

  logic soft_rst;
  assign soft_rst = wr_ctrl & bus_wdata[CB_SRST];

  // Configuration registers
  logic [31:0]      ctrl_q, ctrl_d;
  logic [PRE_W-1:0] pre_q, pre_d;
  flags_t           ien_q, ien_d;
  logic [CNT_W-1:0] cmp_q, cmp_d;
  logic             ctrl_ce, pre_ce, ien_ce, cmp_ce;

  assign ctrl_ce = wr_ctrl;
  assign pre_ce  = wr_pre | soft_rst;
  assign ien_ce  = wr_ien | soft_rst;
  assign cmp_ce  = wr_cmp | soft_rst;

  always_comb begin
    if (soft_rst) begin
      ctrl_d = bus_wdata & ~SRST_DROP;
    end else begin
      ctrl_d = bus_wdata & ~(32'h1 << CB_SRST);
    end
    pre_d = soft_rst ? '0 : bus_wdata[PRE_W-1:0];
    ien_d = soft_rst ? '0 : word_to_flags(bus_wdata);
    cmp_d = soft_rst ? '0 : bus_wdata[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ctrl_q <= '0;
      pre_q  <= '0;
      ien_q  <= '0;
      cmp_q  <= '0;
    end else begin
      if (ctrl_ce) ctrl_q <= ctrl_d;
      if (pre_ce)  pre_q  <= pre_d;
      if (ien_ce)  ien_q  <= ien_d;
      if (cmp_ce)  cmp_q  <= cmp_d;
    end
  end

  logic run, free_mode, start_clear, cnt_clear;
  assign run         = ctrl_q[CB_EN];
  assign free_mode   = ctrl_q[CB_FREE];
  assign start_clear = wr_ctrl & ~soft_rst & ~ctrl_q[CB_EN]
                     & bus_wdata[CB_EN] & bus_wdata[CB_CLRON];
  assign cnt_clear   = soft_rst | start_clear;

  // Tick generation
  logic tick;
  gpt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .run_i   (run),
    .ratio_i (pre_q),
    .tick_o  (tick)
  );

  // Counter
  logic [CNT_W-1:0] cnt;
  logic             ev_match, ev_wrap;
  gpt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .tick_i  (tick),
    .clear_i (cnt_clear),
    .free_i  (free_mode),
    .cmp_i   (cmp_q),
    .cnt_o   (cnt),
    .match_o (ev_match),
    .wrap_o  (ev_wrap)
  );

  // Status and interrupt
  flags_t ev_set, flags;
  assign ev_set.match = ev_match;
  assign ev_set.wrap  = ev_wrap;

  gpt_status u_stat (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wipe_i   (soft_rst),
    .ack_we_i (wr_stat),
    .ack_i    (word_to_flags(bus_wdata)),
    .set_i    (ev_set),
    .ien_i    (ien_q),
    .run_i    (run),
    .flags_o  (flags),
    .irq_o    (irq)
  );

  // Read path
  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (bus_addr)
        ADDR_W'(IDX_CTRL): bus_rdata = ctrl_q;
        ADDR_W'(IDX_PRE):  bus_rdata = 32'(pre_q);
        ADDR_W'(IDX_STAT): bus_rdata = flags_to_word(flags);
        ADDR_W'(IDX_IEN):  bus_rdata = flags_to_word(ien_q);
        ADDR_W'(IDX_CMP):  bus_rdata = 32'(cmp_q);
        ADDR_W'(IDX_CNT):  bus_rdata = 32'(cnt);
        default:           bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpt_timer_chk.sv
module gpt_timer_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             free_mode,
  input logic             tick,
  input logic             cnt_clear,
  input logic             soft_rst,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cmp_q,
  input logic             ev_match,
  input logic             ev_wrap,
  input logic [1:0]       flags,
  input logic             irq
);
  // R8: interrupt only while enabled
  p_irq_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> run);

  // R3: counter holds without tick or clear
  p_cnt_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_clear) |=> $stable(cnt));

  // R3: free-running tick steps by one
  p_cnt_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_clear && free_mode) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

  // R4: ticks only while enabled
  p_tick_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> run);

  // R9: restart reload
  p_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_clear && !free_mode && (cnt == cmp_q)) |=> (cnt == '0));

  // R11: a set event always lands
  p_match_lands_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_match && !soft_rst) |=> flags[0]);

  // R10: wrap event lands
  p_wrap_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_wrap && !soft_rst) |=> flags[1]);

  // R2: software reset empties count and flags
  p_soft_rst_r2: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> ((cnt == '0) && (flags == 2'b00)));
endmodule

bind gp_cmp_timer gpt_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .run       (run),
  .free_mode (free_mode),
  .tick      (tick),
  .cnt_clear (cnt_clear),
  .soft_rst  (soft_rst),
  .cnt       (cnt),
  .cmp_q     (cmp_q),
  .ev_match  (ev_match),
  .ev_wrap   (ev_wrap),
  .flags     (flags),
  .irq       (irq)
);

// File: tb/tb_gp_cmp_timer.sv
module tb_gp_cmp_timer;
  localparam int unsigned AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_sel = 1'b0;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          irq;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  gp_cmp_timer #(.CNT_W(8), .PRE_W(12), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] data);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = AW'(idx); bus_wdata = data;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input int idx, output logic [31:0] data);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = AW'(idx);
    #1;
    data = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_reg(input string req, input int idx, input logic [31:0] exp);
    logic [31:0] v;
    rd(idx, v);
    check(req, v, exp);
  endtask

  task automatic t_reset;
    expect_reg("R1 ctrl", 0, 0);
    expect_reg("R1 pre", 1, 0);
    expect_reg("R1 stat", 2, 0);
    expect_reg("R1 ien", 3, 0);
    expect_reg("R1 cmp", 4, 0);
    expect_reg("R1 cnt", 9, 0);
    check("R1 irq", 32'(irq), 0);
  endtask

  task automatic t_count;
    wr(0, 32'h8000);
    wr(0, 32'h201);
    wait_cyc(10);
    expect_reg("R3 count", 9, 10);
  endtask

  task automatic t_prescale;
    wr(0, 32'h8000);
    wr(1, 32'd3);
    wr(0, 32'h201);
    wait_cyc(3);
    expect_reg("R4 before first tick", 9, 0);
    wait_cyc(10);
    expect_reg("R4 three ticks", 9, 3);
    wr(0, 32'h200);
    wait_cyc(10);
    expect_reg("R3 hold disabled", 9, 3);
    wr(0, 32'h201);
    expect_reg("R5 no clear without mode", 9, 3);
    wr(0, 32'h200);
    wr(0, 32'h203);
    expect_reg("R5 clear on enable", 9, 0);
    wait_cyc(3);
    expect_reg("R4 restart divider", 9, 0);
    wait_cyc(1);
    expect_reg("R4 first tick", 9, 1);
  endtask

  task automatic t_match_free;
    wr(0, 32'h8000);
    wr(4, 32'd5);
    wr(3, 32'h1);
    wr(0, 32'h201);
    wait_cyc(4);
    expect_reg("R6 before match", 2, 0);
    check("R8 irq before", 32'(irq), 0);
    wait_cyc(1);
    expect_reg("R6 match flag", 2, 32'h1);
    check("R8 irq on match", 32'(irq), 1);
    wait_cyc(2);
    expect_reg("R6 free run continues", 9, 7);
    wr(2, 32'h20);
    expect_reg("R7 zero leaves flag", 2, 32'h1);
    wr(2, 32'h1);
    expect_reg("R7 w1c", 2, 0);
    check("R8 irq cleared", 32'(irq), 0);
  endtask

  task automatic t_irq_gate;
    wr(0, 32'h8000);
    wr(4, 32'd2);
    wr(0, 32'h201);
    wait_cyc(3);
    expect_reg("R8 flag pending", 2, 32'h1);
    check("R8 irq masked", 32'(irq), 0);
    wr(3, 32'h1);
    check("R8 irq unmasked", 32'(irq), 1);
    wr(0, 32'h200);
    check("R8 irq off when disabled", 32'(irq), 0);
    expect_reg("R8 flag kept", 2, 32'h1);
  endtask

  task automatic t_restart;
    wr(0, 32'h8000);
    wr(4, 32'd3);
    wr(0, 32'h1);
    wait_cyc(3);
    expect_reg("R9 at compare", 9, 3);
    wait_cyc(1);
    expect_reg("R9 reload", 9, 0);
    wait_cyc(3);
    expect_reg("R9 second period", 9, 3);
  endtask

  task automatic t_wrap_and_race;
    wr(0, 32'h8000);
    wr(4, 32'd100);
    wr(3, 32'h20);
    wr(0, 32'h201);
    wait_cyc(255);
    expect_reg("R10 top", 9, 255);
    expect_reg("R10 no wrap yet", 2, 32'h1);
    check("R10 irq low", 32'(irq), 0);
    wait_cyc(1);
    expect_reg("R10 wrapped", 9, 0);
    expect_reg("R10 wrap flag", 2, 32'h21);
    check("R10 irq", 32'(irq), 1);
    wr(2, 32'h1);
    expect_reg("R7 clear match only", 2, 32'h20);
    wait_cyc(98);
    wr(2, 32'h1);
    expect_reg("R11 set wins", 2, 32'h21);
    wr(2, 32'h21);
    expect_reg("R7 clear both", 2, 0);
  endtask

  task automatic t_soft_reset;
    wr(1, 32'd7);
    wr(3, 32'h21);
    wr(4, 32'd9);
    wr(0, 32'hFFFF_FFFF);
    expect_reg("R2 ctrl kept bits", 0, 32'hFFFF_7FE2);
    expect_reg("R2 pre", 1, 0);
    expect_reg("R2 stat", 2, 0);
    expect_reg("R2 ien", 3, 0);
    expect_reg("R2 cmp", 4, 0);
    expect_reg("R2 cnt", 9, 0);
    wait_cyc(5);
    expect_reg("R2 stays stopped", 9, 0);
  endtask

  task automatic t_map;
    wr(5, 32'hFFFF_FFFF);
    expect_reg("R1 unmapped", 5, 0);
    wr(9, 32'h55);
    expect_reg("R1 counter read-only", 9, 0);
    wr(1, 32'hFFFF_F123);
    expect_reg("R1 prescaler width", 1, 32'h123);
    expect_reg("R1 unmapped 15", 15, 0);
  endtask

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(4);
    t_reset();
    t_count();
    t_prescale();
    t_match_free();
    t_irq_gate();
    t_restart();
    t_wrap_and_race();
    t_soft_reset();
    t_map();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule